// File: doc/BRIEF.md
# Branch Resolve and Flush Control

This block selects the next fetch address of a five-stage in-order pipeline and tells the fetch and decode stages which of their instructions must become bubbles. Jump targets and branch targets are both formed while the instruction sits in decode. A jump redirects fetch at once. A conditional branch carries its target and its condition into an internal execute slot. It is resolved there one cycle later from the zero flag that the ALU returns.

A jump costs one cycle: only the instruction being fetched behind it is squashed. A taken branch costs two cycles: the instruction in decode and the one in fetch are both squashed. The block remembers which decode slot holds a squashed instruction. That instruction's jump and branch flags are then ignored, and its write enables are cleared before they reach the execute slot. A squashed instruction therefore changes no register or memory state.

Top module: `branch_flush_ctl`

## Requirements
- R1: When `kill_if` is 0, `next_pc` equals `fetch_pc + 4`.
- R2: A jump in a live decode slot makes `next_pc` equal to bits [31:28] of `dec_pc_plus4`, then `dec_jfield`, then two zero bits. In that same cycle `kill_if` is 1 and `kill_id` is 0.
- R3: A branch target is `dec_pc_plus4` plus the sign-extended `dec_imm` shifted left by two. It is taken from the decode cycle and applied to `next_pc` in the following cycle when the branch is taken.
- R4: A branch in the execute slot is taken when it is branch-equal and `ex_zero` is 1, or branch-not-equal and `ex_zero` is 0. `ex_branch_taken` is 1 in exactly those cycles.
- R5: In a cycle with a taken branch, `kill_if` and `kill_id` are both 1. A branch that is not taken asserts neither, and `next_pc` is `fetch_pc + 4`.
- R6: A taken branch in execute wins over a jump in decode in the same cycle: `next_pc` is the branch target.
- R7: In the cycle after `kill_if` is 1, the decode slot is squashed. Jump or branch flags presented for it have no effect on `next_pc`, the kills, or the next cycle's `ex_branch_taken`.
- R8: `ex_reg_write` and `ex_mem_write` are the decode write enables of the previous cycle. They are forced to 0 when that decode slot was squashed or killed.
- R9: Immediately after reset, the kills, `ex_branch_taken`, `ex_reg_write` and `ex_mem_write` are 0. The decode flags of the first cycle after reset are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_pc | input | 32 | Address of the instruction being fetched |
| dec_pc_plus4 | input | 32 | Address after the instruction in decode |
| dec_jfield | input | 26 | Jump address field of the decode instruction |
| dec_imm | input | 16 | Branch word offset of the decode instruction |
| dec_jump | input | 1 | Decode instruction is a jump |
| dec_beq | input | 1 | Decode instruction is branch-if-equal |
| dec_bne | input | 1 | Decode instruction is branch-if-not-equal |
| dec_reg_write | input | 1 | Register write enable of the decode instruction |
| dec_mem_write | input | 1 | Memory write enable of the decode instruction |
| ex_zero | input | 1 | Zero flag from the ALU for the execute instruction |
| next_pc | output | 32 | Next fetch address |
| kill_if | output | 1 | Turn the instruction fetched this cycle into a bubble |
| kill_id | output | 1 | Turn the instruction in decode into a bubble |
| ex_branch_taken | output | 1 | Branch in the execute slot is taken |
| ex_reg_write | output | 1 | Register write enable held in the execute slot |
| ex_mem_write | output | 1 | Memory write enable held in the execute slot |

## Verification
A taken branch in execute and a jump in decode can fall in the same cycle, because the jump is the first instruction fetched after the branch. The bench provokes this by driving a jump with its own target into decode in the cycle where the earlier branch-equal meets `ex_zero` at 1. It then checks that `next_pc` is the branch target and that both kills are raised. In the next cycle it checks that the jump's register write never reached the execute slot. Finally, the squashed follower's branch flag is offered with the zero flag still set, and the bench confirms that no second redirect follows.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned ADDR_W  = 32;
    localparam int unsigned JFLD_W  = 26;
    localparam int unsigned OFS_W   = 16;
    localparam int unsigned STEP    = 4;

    typedef struct packed {
        logic is_beq;
        logic is_bne;
        logic reg_we;
        logic mem_we;
    } slot_ctl_t;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_JUMP   = 2'd1,
        SEL_BRANCH = 2'd2
    } pc_sel_t;

    localparam slot_ctl_t SLOT_EMPTY = '{is_beq: 1'b0, is_bne: 1'b0,
                                         reg_we: 1'b0, mem_we: 1'b0};

    function automatic slot_ctl_t gate_slot(input slot_ctl_t c, input logic live);
        slot_ctl_t r;
        r = live ? c : SLOT_EMPTY;
        return r;
    endfunction

    function automatic logic cond_met(input slot_ctl_t c, input logic zero);
        return (c.is_beq & zero) | (c.is_bne & ~zero);
    endfunction

endpackage

// File: rtl/npc_target_gen.sv
module npc_target_gen #(
    parameter int unsigned AW = npc_pkg::ADDR_W,
    parameter int unsigned JW = npc_pkg::JFLD_W,
    parameter int unsigned OW = npc_pkg::OFS_W
) (
    input  logic [AW-1:0] pc_plus4,
    input  logic [JW-1:0] jfield,
    input  logic [OW-1:0] imm,
    output logic [AW-1:0] jump_tgt,
    output logic [AW-1:0] br_tgt
);
    localparam int unsigned HI_W  = AW - JW - 2;
    localparam int unsigned EXT_W = AW - OW;

    logic [AW-1:0] offset_ext;
    logic [AW-1:0] offset_bytes;

    generate
        if (HI_W > 0) begin : g_region
            assign jump_tgt = {pc_plus4[AW-1 -: HI_W], jfield, 2'b00};
        end else begin : g_flat
            assign jump_tgt = {jfield[AW-3:0], 2'b00};
        end
    endgenerate

    always_comb begin
        offset_ext   = {{EXT_W{imm[OW-1]}}, imm};
        offset_bytes = offset_ext << 2;
        br_tgt       = pc_plus4 + offset_bytes;
    end

endmodule

// File: rtl/npc_ex_slot.sv
module npc_ex_slot
    import npc_pkg::*;
#(
    parameter int unsigned AW = npc_pkg::ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  slot_ctl_t       d_ctl,
    input  logic            d_live,
    input  logic [AW-1:0]   d_tgt,
    input  logic            zero,
    output slot_ctl_t       q_ctl,
    output logic [AW-1:0]   q_tgt,
    output logic            taken
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_ctl <= SLOT_EMPTY;
            q_tgt <= '0;
        end else begin
            q_ctl <= gate_slot(d_ctl, d_live);
            q_tgt <= d_tgt;
        end
    end

    always_comb begin
        taken = cond_met(q_ctl, zero);
    end

endmodule

// File: rtl/npc_squash_track.sv
module npc_squash_track (
    input  logic clk,
    input  logic rst,
    input  logic fetch_killed,
    output logic dec_dead
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dec_dead <= 1'b1;
        end else begin
            dec_dead <= fetch_killed;
        end
    end

endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
#(
    parameter int unsigned AW   = npc_pkg::ADDR_W,
    parameter int unsigned INCR = npc_pkg::STEP
) (
    input  logic [AW-1:0] fetch_pc,
    input  logic [AW-1:0] jump_tgt,
    input  logic [AW-1:0] br_tgt,
    input  logic          br_taken,
    input  logic          jump_live,
    output logic [AW-1:0] next_pc,
    output logic          kill_if,
    output logic          kill_id
);
    localparam logic [AW-1:0] INC_V = AW'(INCR);

    pc_sel_t sel;

    always_comb begin
        if (br_taken) begin
            sel = SEL_BRANCH;
        end else if (jump_live) begin
            sel = SEL_JUMP;
        end else begin
            sel = SEL_SEQ;
        end

        unique case (sel)
            SEL_BRANCH: next_pc = br_tgt;
            SEL_JUMP:   next_pc = jump_tgt;
            default:    next_pc = fetch_pc + INC_V;
        endcase

        kill_if = (sel != SEL_SEQ);
        kill_id = (sel == SEL_BRANCH);
    end

endmodule

// File: rtl/branch_flush_ctl.sv
module branch_flush_ctl
    import npc_pkg::*;
#(
    parameter int unsigned AW = npc_pkg::ADDR_W,
    parameter int unsigned JW = npc_pkg::JFLD_W,
    parameter int unsigned OW = npc_pkg::OFS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] fetch_pc,
    input  logic [AW-1:0] dec_pc_plus4,
    input  logic [JW-1:0] dec_jfield,
    input  logic [OW-1:0] dec_imm,
    input  logic          dec_jump,
    input  logic          dec_beq,
    input  logic          dec_bne,
    input  logic          dec_reg_write,
    input  logic          dec_mem_write,
    input  logic          ex_zero,
    output logic [AW-1:0] next_pc,
    output logic          kill_if,
    output logic          kill_id,
    output logic          ex_branch_taken,
    output logic          ex_reg_write,
    output logic          ex_mem_write
);
    logic [AW-1:0] jump_tgt;
    logic [AW-1:0] dec_br_tgt;
    logic [AW-1:0] ex_br_tgt;
    logic          dec_dead;
    logic          dec_live;
    logic          jump_live;
    slot_ctl_t     dec_ctl;
    slot_ctl_t     ex_ctl;

    npc_target_gen #(.AW(AW), .JW(JW), .OW(OW)) u_tgt (
        .pc_plus4 (dec_pc_plus4),
        .jfield   (dec_jfield),
        .imm      (dec_imm),
        .jump_tgt (jump_tgt),
        .br_tgt   (dec_br_tgt)
    );

    npc_squash_track u_track (
        .clk          (clk),
        .rst          (rst),
        .fetch_killed (kill_if),
        .dec_dead     (dec_dead)
    );

    always_comb begin
        dec_ctl.is_beq = dec_beq;
        dec_ctl.is_bne = dec_bne;
        dec_ctl.reg_we = dec_reg_write;
        dec_ctl.mem_we = dec_mem_write;
        dec_live       = ~dec_dead & ~ex_branch_taken;
        jump_live      = dec_jump & ~dec_dead;
    end

    npc_ex_slot #(.AW(AW)) u_ex (
        .clk    (clk),
        .rst    (rst),
        .d_ctl  (dec_ctl),
        .d_live (dec_live),
        .d_tgt  (dec_br_tgt),
        .zero   (ex_zero),
        .q_ctl  (ex_ctl),
        .q_tgt  (ex_br_tgt),
        .taken  (ex_branch_taken)
    );

    npc_select #(.AW(AW)) u_sel (
        .fetch_pc  (fetch_pc),
        .jump_tgt  (jump_tgt),
        .br_tgt    (ex_br_tgt),
        .br_taken  (ex_branch_taken),
        .jump_live (jump_live),
        .next_pc   (next_pc),
        .kill_if   (kill_if),
        .kill_id   (kill_id)
    );

    assign ex_reg_write = ex_ctl.reg_we;
    assign ex_mem_write = ex_ctl.mem_we;

endmodule

// File: rtl/branch_flush_ctl_chk.sv
module branch_flush_ctl_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] fetch_pc,
    input logic [AW-1:0] next_pc,
    input logic          kill_if,
    input logic          kill_id,
    input logic          ex_branch_taken,
    input logic          ex_reg_write,
    input logic          ex_mem_write
);
    // R1: without a fetch kill the address steps by one word
    a_r1_seq_step: assert property (@(posedge clk) disable iff (rst)
        !kill_if |-> next_pc == fetch_pc + AW'(4));

    // R5: a decode kill never comes without a fetch kill
    a_r5_id_kill_has_if_kill: assert property (@(posedge clk) disable iff (rst)
        kill_id |-> kill_if);

    // R7: a squashed decode slot cannot raise a jump redirect
    a_r7_no_jump_after_kill: assert property (@(posedge clk) disable iff (rst)
        kill_if |=> !(kill_if && !kill_id));

    // R7: the slot after a taken branch is a bubble
    a_r7_taken_then_bubble: assert property (@(posedge clk) disable iff (rst)
        ex_branch_taken |=> !ex_branch_taken);

    // R8: a killed decode instruction reaches execute with no write enables
    a_r8_killed_no_writes: assert property (@(posedge clk) disable iff (rst)
        kill_id |=> (!ex_reg_write && !ex_mem_write));

    // R9: first cycle after reset is quiet
    a_r9_quiet_after_reset: assert property (@(posedge clk)
        $fell(rst) |-> (!kill_if && !kill_id && !ex_reg_write && !ex_mem_write));

endmodule

bind branch_flush_ctl branch_flush_ctl_chk #(.AW(AW)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .fetch_pc        (fetch_pc),
    .next_pc         (next_pc),
    .kill_if         (kill_if),
    .kill_id         (kill_id),
    .ex_branch_taken (ex_branch_taken),
    .ex_reg_write    (ex_reg_write),
    .ex_mem_write    (ex_mem_write)
);

// File: tb/tb_branch_flush_ctl.sv
module tb_branch_flush_ctl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_pc = '0;
    logic [31:0] dec_pc_plus4 = '0;
    logic [25:0] dec_jfield = '0;
    logic [15:0] dec_imm = '0;
    logic        dec_jump = 1'b0;
    logic        dec_beq = 1'b0;
    logic        dec_bne = 1'b0;
    logic        dec_reg_write = 1'b0;
    logic        dec_mem_write = 1'b0;
    logic        ex_zero = 1'b0;
    logic [31:0] next_pc;
    logic        kill_if;
    logic        kill_id;
    logic        ex_branch_taken;
    logic        ex_reg_write;
    logic        ex_mem_write;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_flush_ctl dut (
        .clk (clk), .rst (rst), .fetch_pc (fetch_pc),
        .dec_pc_plus4 (dec_pc_plus4), .dec_jfield (dec_jfield), .dec_imm (dec_imm),
        .dec_jump (dec_jump), .dec_beq (dec_beq), .dec_bne (dec_bne),
        .dec_reg_write (dec_reg_write), .dec_mem_write (dec_mem_write),
        .ex_zero (ex_zero), .next_pc (next_pc), .kill_if (kill_if), .kill_id (kill_id),
        .ex_branch_taken (ex_branch_taken), .ex_reg_write (ex_reg_write),
        .ex_mem_write (ex_mem_write)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_inputs();
        dec_jump = 0; dec_beq = 0; dec_bne = 0;
        dec_reg_write = 0; dec_mem_write = 0; ex_zero = 0;
        dec_imm = '0; dec_jfield = '0; dec_pc_plus4 = '0;
    endtask

    task automatic drain();
        idle_inputs();
        step(); step();
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        fetch_pc = 32'h0000_0100;
        dec_jump = 1; dec_jfield = 26'h3FF_FFFF; dec_pc_plus4 = 32'hF000_0000;
        dec_reg_write = 1; dec_mem_write = 1;
        settle();
        chk("R9 kill_if after reset", {31'd0, kill_if}, 32'd0);
        chk("R9 kill_id after reset", {31'd0, kill_id}, 32'd0);
        chk("R9 taken after reset", {31'd0, ex_branch_taken}, 32'd0);
        chk("R9 next_pc ignores first decode", next_pc, 32'h0000_0104);
        chk("R9 ex_reg_write after reset", {31'd0, ex_reg_write}, 32'd0);
        step();
        chk("R9 first decode writes dropped", {30'd0, ex_reg_write, ex_mem_write}, 32'd0);
        drain();
    endtask

    task automatic t_sequential();
        fetch_pc = 32'h0000_0400;
        settle();
        chk("R1 sequential next_pc", next_pc, 32'h0000_0404);
        chk("R1 no kills", {30'd0, kill_if, kill_id}, 32'd0);
        fetch_pc = 32'hFFFF_FFFC;
        settle();
        chk("R1 wrap next_pc", next_pc, 32'h0000_0000);
        drain();
    endtask

    task automatic t_jump();
        fetch_pc = 32'hA000_0014;
        dec_pc_plus4 = 32'hA000_0010; dec_jfield = 26'h012_3456;
        dec_jump = 1; dec_reg_write = 1;
        settle();
        chk("R2 jump target", next_pc, 32'hA048_D158);
        chk("R2 jump kill_if", {31'd0, kill_if}, 32'd1);
        chk("R2 jump kill_id", {31'd0, kill_id}, 32'd0);
        step();
        chk("R8 live jump write reaches ex", {31'd0, ex_reg_write}, 32'd1);
        fetch_pc = 32'hA048_D158;
        dec_jfield = 26'h000_0001;
        settle();
        chk("R7 squashed jump ignored next_pc", next_pc, 32'hA048_D15C);
        chk("R7 squashed jump no kill", {31'd0, kill_if}, 32'd0);
        step();
        chk("R8 squashed slot writes cleared", {31'd0, ex_reg_write}, 32'd0);
        drain();
    endtask

    task automatic t_beq_taken_vs_jump();
        fetch_pc = 32'h0000_1004;
        dec_pc_plus4 = 32'h0000_1000; dec_imm = 16'hFFFE; dec_beq = 1;
        settle();
        chk("R5 branch in decode no kill", {30'd0, kill_if, kill_id}, 32'd0);
        step();
        dec_beq = 0;
        fetch_pc = 32'h0000_1008;
        dec_jump = 1; dec_jfield = 26'h000_0040; dec_pc_plus4 = 32'h0000_1004;
        dec_reg_write = 1; ex_zero = 1;
        settle();
        chk("R4 beq taken on zero", {31'd0, ex_branch_taken}, 32'd1);
        chk("R3 R6 branch target wins over jump", next_pc, 32'h0000_0FF8);
        chk("R5 taken kills both", {30'd0, kill_if, kill_id}, 32'd3);
        step();
        chk("R8 killed decode writes cleared", {30'd0, ex_reg_write, ex_mem_write}, 32'd0);
        dec_jump = 0; dec_reg_write = 0;
        dec_beq = 1; ex_zero = 1; fetch_pc = 32'h0000_0FF8;
        settle();
        chk("R7 after taken no redirect", {31'd0, kill_if}, 32'd0);
        step();
        dec_beq = 0;
        settle();
        chk("R7 squashed beq not resolved", {31'd0, ex_branch_taken}, 32'd0);
        drain();
    endtask

    task automatic t_beq_not_taken();
        fetch_pc = 32'h0000_3004;
        dec_pc_plus4 = 32'h0000_3000; dec_imm = 16'h0100; dec_beq = 1;
        step();
        dec_beq = 0; ex_zero = 0; fetch_pc = 32'h0000_3008;
        dec_reg_write = 1; dec_mem_write = 1;
        settle();
        chk("R4 beq not taken when zero=0", {31'd0, ex_branch_taken}, 32'd0);
        chk("R5 not taken falls through", next_pc, 32'h0000_300C);
        chk("R5 not taken no kills", {30'd0, kill_if, kill_id}, 32'd0);
        step();
        chk("R8 follower writes pass", {30'd0, ex_reg_write, ex_mem_write}, 32'd3);
        drain();
    endtask

    task automatic t_bne();
        fetch_pc = 32'h0000_2004;
        dec_pc_plus4 = 32'h0000_2000; dec_imm = 16'h0010; dec_bne = 1;
        step();
        dec_bne = 0; ex_zero = 0; fetch_pc = 32'h0000_2008;
        settle();
        chk("R4 bne taken when zero=0", {31'd0, ex_branch_taken}, 32'd1);
        chk("R3 bne target", next_pc, 32'h0000_2040);
        drain();
        fetch_pc = 32'h0000_5004;
        dec_pc_plus4 = 32'h0000_5000; dec_imm = 16'h0010; dec_bne = 1;
        step();
        dec_bne = 0; ex_zero = 1; fetch_pc = 32'h0000_5008;
        settle();
        chk("R4 bne not taken when zero=1", {31'd0, ex_branch_taken}, 32'd0);
        chk("R5 bne not taken next_pc", next_pc, 32'h0000_500C);
        drain();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_sequential();
        t_jump();
        t_beq_taken_vs_jump();
        t_beq_not_taken();
        t_bne();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule